// File: doc/BRIEF.md
# Shared Interrupt Distributor Register Bank

This block holds the per-interrupt configuration and state for a parameterised set of shared interrupt lines (`NUM_IRQ`, a multiple of 32, default 64). For every line it keeps an enable bit, a pending bit, an active bit, a group bit, a trigger mode and a priority. Software reaches all of this through a simple 32-bit register port. Enable, pending and active each have two views: a set view and a clear view. A one written to either view changes the bit, and a zero leaves it unchanged.

Interrupt inputs are sampled on the block clock. A line in edge mode latches pending on a rising input. A line in level mode is pending while its input is high or while software holds it pending.

A combinational selector reports the most urgent candidate. A candidate is pending, enabled, not active, and its group is enabled. Among candidates, the lowest priority value wins, and on a tie the lowest ID wins. A control register holds the two group enables and a routing-mode bit. Its top bit is a busy flag that rises for a few cycles after control or clear-enable writes, so that software can wait for those writes to settle.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset, all per-interrupt state and all control bits are 0, `best_valid` is 0 and `best_id` is 1023. A read strobed at a clock edge returns its word on `reg_rdata` after that edge, and `reg_rdata` holds its value when no read is strobed.
- R2: Enable bits are at 0x200 (set view) and 0x280 (clear view). Active bits are at 0x400 (set view) and 0x480 (clear view). Word w at offset 4*w covers IDs 32w..32w+31, with ID i in bit i mod 32. A one written sets or clears that bit, a zero has no effect, and both views read the current state.
- R3: Pending bits use the same layout, with the set view at 0x300 and the clear view at 0x380. Both views read the effective pending state.
- R4: Trigger fields are at 0xC00 + 4*(i/16), two bits per ID starting at bit 2*(i mod 16). The upper bit of a field selects edge mode (1) or level mode (0), and the lower bit always reads 0. In edge mode a rising input latches pending, which stays set after the input falls until it is cleared. A level that stays high does not re-latch.
- R5: In level mode an ID is pending while its input is high or while its software pending bit is set. A clear-view write does not remove pending while the input is still high.
- R6: Priorities are at 0x800 + 4*(i/4), with ID i in byte i mod 4. Only the upper `PRIO_BITS` (default 5) bits of each byte are stored, so a write of 0xFF reads back as 0xF8.
- R7: The group bits are at 0x100, laid out as in R2 (0 means group 0, 1 means group 1). The control word at 0x000 holds the group 0 enable in bit 0, the group 1 enable in bit 1 and the routing enable in bit 4. These bits read back as written.
- R8: Control bit 31 is a read-only busy flag. It reads 1 for exactly `BUSY_CYCLES` (default 4) clock edges after any write to the control word or to any clear-enable word, then reads 0. Writes to bit 31 are ignored.
- R9: The type word at 0x004 returns `NUM_IRQ`/32 - 1 in bits 4:0 and 0 in all other bits.
- R10: The status word for ID i is at 0x1000 + 4*i. It returns active in bit 1, pending in bit 0, and 0 in all other bits.
- R11: A line qualifies for selection when it is pending, enabled and not active, and its group is enabled. `best_id` is the qualifying ID with the lowest priority value, with ties going to the lowest ID. `best_prio` is that line's priority byte. Both follow the state without a register stage.
- R12: When no line qualifies, `best_valid` is 0, `best_id` is 1023 and `best_prio` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 13 | Byte address of the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_in | input | NUM_IRQ | Interrupt input lines |
| best_valid | output | 1 | A qualifying line exists |
| best_id | output | 10 | ID of the selected line, 1023 if none |
| best_prio | output | 8 | Priority byte of the selected line |

## Verification
A register write takes effect at the edge that samples it. The selector outputs therefore show the new state from that edge on, and the bench samples them at the following falling edge. A rising input in edge mode is latched at the next edge. A read returns its data after the edge that samples the strobe, so the bench queues each expected word when it drives the read and compares it at the falling edge after. Reads are issued back-to-back after a control or clear-enable write, so the busy flag is counted edge by edge: four busy reads, then one clear read.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

  localparam int unsigned AW  = 13;
  localparam int unsigned IDW = 10;

  localparam logic [AW-1:0] OFS_CTRL   = 13'h0000;
  localparam logic [AW-1:0] OFS_TYPE   = 13'h0004;
  localparam logic [AW-1:0] OFS_GROUP  = 13'h0100;
  localparam logic [AW-1:0] OFS_EN_SET = 13'h0200;
  localparam logic [AW-1:0] OFS_EN_CLR = 13'h0280;
  localparam logic [AW-1:0] OFS_PD_SET = 13'h0300;
  localparam logic [AW-1:0] OFS_PD_CLR = 13'h0380;
  localparam logic [AW-1:0] OFS_AC_SET = 13'h0400;
  localparam logic [AW-1:0] OFS_AC_CLR = 13'h0480;
  localparam logic [AW-1:0] OFS_PRIO   = 13'h0800;
  localparam logic [AW-1:0] OFS_CFG    = 13'h0C00;
  localparam logic [AW-1:0] OFS_STAT   = 13'h1000;

  localparam int unsigned CTRL_G0    = 0;
  localparam int unsigned CTRL_G1    = 1;
  localparam int unsigned CTRL_ROUTE = 4;

  localparam logic [IDW-1:0] ID_NONE = 10'd1023;

  // byte address of the idx-th word of a window
  function automatic logic [AW-1:0] word_addr(input logic [AW-1:0] base,
                                              input int unsigned idx);
    return base + AW'(idx * 4);
  endfunction

  // type word: number of 32-line words minus one, in the low five bits
  function automatic logic [31:0] type_word(input int unsigned n);
    logic [31:0] t;
    t      = '0;
    t[4:0] = 5'((n / 32) - 1);
    return t;
  endfunction

  // per-line status word: active above pending
  function automatic logic [31:0] status_word(input logic act, input logic pend);
    return {30'd0, act, pend};
  endfunction

endpackage

// File: rtl/irq_bit_bank.sv
module irq_bit_bank #(
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_mask,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_mask) | set_mask;
  end

  assert_w1s_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask) |=> ((q & $past(set_mask)) == $past(set_mask)));

  assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((q & $past(clr_mask)) == '0));

endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] edge_mode,
  input  logic [N-1:0] set_mask,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pend
);

  logic [N-1:0] irq_q;
  logic [N-1:0] sw_q;
  logic [N-1:0] edge_hit;

  // rising input on an edge-mode line
  assign edge_hit = irq_in & ~irq_q & edge_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      sw_q  <= '0;
    end else begin
      irq_q <= irq_in;
      // a hardware edge wins over a clear in the same cycle
      sw_q  <= (sw_q & ~clr_mask) | set_mask | edge_hit;
    end
  end

  // level-mode lines also follow the live input
  assign pend = sw_q | (~edge_mode & irq_in);

  assert_edge_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((sw_q & $past(edge_hit)) == $past(edge_hit)));

  assert_sw_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~edge_hit & ~set_mask)) |=>
      ((sw_q & $past(clr_mask & ~edge_hit & ~set_mask)) == '0));

endmodule

// File: rtl/irq_best_pick.sv
module irq_best_pick
  import irq_dist_pkg::*;
#(
  parameter int unsigned N  = 64,
  parameter int unsigned PB = 5
) (
  input  logic [N-1:0]    elig,
  input  logic [N*PB-1:0] prio_flat,
  output logic            found,
  output logic [IDW-1:0]  id,
  output logic [PB-1:0]   prio
);

  // ascending scan; only a strictly smaller value displaces, so ties keep the lower ID
  always_comb begin
    found = 1'b0;
    id    = ID_NONE;
    prio  = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (elig[i] && (!found || (prio_flat[i*PB +: PB] < prio))) begin
        found = 1'b1;
        id    = IDW'(i);
        prio  = prio_flat[i*PB +: PB];
      end
    end
  end

endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_IRQ     = 64,
  parameter int unsigned PRIO_BITS   = 5,
  parameter int unsigned BUSY_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [AW-1:0]      reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic               best_valid,
  output logic [IDW-1:0]     best_id,
  output logic [7:0]         best_prio
);

  localparam int unsigned WORDS  = NUM_IRQ / 32;
  localparam int unsigned PWORDS = NUM_IRQ / 4;
  localparam int unsigned CWORDS = NUM_IRQ / 16;
  localparam int unsigned CNTW   = $clog2(BUSY_CYCLES + 1);

  // left-justify a stored priority into its byte lane
  function automatic logic [7:0] prio_byte(input logic [PRIO_BITS-1:0] p);
    logic [7:0] b;
    b = '0;
    b[7 -: PRIO_BITS] = p;
    return b;
  endfunction

  // ---------------- write decode ----------------
  logic [NUM_IRQ-1:0] en_set, en_clr, pd_set, pd_clr, ac_set, ac_clr;
  logic [WORDS-1:0]   grp_we;
  logic [PWORDS-1:0]  prio_we;
  logic [CWORDS-1:0]  cfg_we;
  logic               ctrl_we;
  logic               clren_we;

  always_comb begin
    en_set = '0; en_clr = '0; pd_set = '0; pd_clr = '0; ac_set = '0; ac_clr = '0;
    grp_we = '0; prio_we = '0; cfg_we = '0;
    clren_we = 1'b0;
    ctrl_we  = reg_wr && (reg_addr == OFS_CTRL);
    for (int w = 0; w < int'(WORDS); w++) begin
      if (reg_wr) begin
        if (reg_addr == word_addr(OFS_EN_SET, w)) en_set[w*32 +: 32] = reg_wdata;
        if (reg_addr == word_addr(OFS_EN_CLR, w)) begin
          en_clr[w*32 +: 32] = reg_wdata;
          clren_we = 1'b1;
        end
        if (reg_addr == word_addr(OFS_PD_SET, w)) pd_set[w*32 +: 32] = reg_wdata;
        if (reg_addr == word_addr(OFS_PD_CLR, w)) pd_clr[w*32 +: 32] = reg_wdata;
        if (reg_addr == word_addr(OFS_AC_SET, w)) ac_set[w*32 +: 32] = reg_wdata;
        if (reg_addr == word_addr(OFS_AC_CLR, w)) ac_clr[w*32 +: 32] = reg_wdata;
        grp_we[w] = (reg_addr == word_addr(OFS_GROUP, w));
      end
    end
    for (int p = 0; p < int'(PWORDS); p++)
      prio_we[p] = reg_wr && (reg_addr == word_addr(OFS_PRIO, p));
    for (int c = 0; c < int'(CWORDS); c++)
      cfg_we[c] = reg_wr && (reg_addr == word_addr(OFS_CFG, c));
  end

  // ---------------- state ----------------
  logic [NUM_IRQ-1:0]   en_q, act_q, pend_w;
  logic [NUM_IRQ-1:0]   grp_q, edge_q;
  logic [PRIO_BITS-1:0] prio_q [NUM_IRQ];
  logic                 g0_en_q, g1_en_q, route_q;
  logic [CNTW-1:0]      busy_cnt;
  logic                 busy_w;
  logic [31:0]          rd_word;

  irq_bit_bank #(.N(NUM_IRQ)) u_enable (
    .clk(clk), .rst_n(rst_n), .set_mask(en_set), .clr_mask(en_clr), .q(en_q));

  irq_bit_bank #(.N(NUM_IRQ)) u_active (
    .clk(clk), .rst_n(rst_n), .set_mask(ac_set), .clr_mask(ac_clr), .q(act_q));

  irq_pend_unit #(.N(NUM_IRQ)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .edge_mode(edge_q),
    .set_mask(pd_set), .clr_mask(pd_clr), .pend(pend_w));

  assign busy_w = (busy_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g0_en_q   <= 1'b0;
      g1_en_q   <= 1'b0;
      route_q   <= 1'b0;
      busy_cnt  <= '0;
      grp_q     <= '0;
      edge_q    <= '0;
      prio_q    <= '{default: '0};
      reg_rdata <= '0;
    end else begin
      if (ctrl_we) begin
        g0_en_q <= reg_wdata[CTRL_G0];
        g1_en_q <= reg_wdata[CTRL_G1];
        route_q <= reg_wdata[CTRL_ROUTE];
      end
      if (ctrl_we || clren_we)  busy_cnt <= CNTW'(BUSY_CYCLES);
      else if (busy_w)          busy_cnt <= busy_cnt - CNTW'(1);
      for (int w = 0; w < int'(WORDS); w++)
        if (grp_we[w]) grp_q[w*32 +: 32] <= reg_wdata;
      for (int i = 0; i < int'(NUM_IRQ); i++) begin
        if (prio_we[i/4]) prio_q[i] <= reg_wdata[8*(i%4)+7 -: PRIO_BITS];
        if (cfg_we[i/16]) edge_q[i] <= reg_wdata[2*(i%16)+1];
      end
      if (reg_rd) reg_rdata <= rd_word;
    end
  end

  // ---------------- read mux ----------------
  always_comb begin
    rd_word = '0;
    if (reg_addr == OFS_CTRL)
      rd_word = {busy_w, 26'd0, route_q, 2'd0, g1_en_q, g0_en_q};
    if (reg_addr == OFS_TYPE)
      rd_word = type_word(NUM_IRQ);
    for (int w = 0; w < int'(WORDS); w++) begin
      if (reg_addr == word_addr(OFS_GROUP, w)) rd_word = grp_q[w*32 +: 32];
      if (reg_addr == word_addr(OFS_EN_SET, w) || reg_addr == word_addr(OFS_EN_CLR, w))
        rd_word = en_q[w*32 +: 32];
      if (reg_addr == word_addr(OFS_PD_SET, w) || reg_addr == word_addr(OFS_PD_CLR, w))
        rd_word = pend_w[w*32 +: 32];
      if (reg_addr == word_addr(OFS_AC_SET, w) || reg_addr == word_addr(OFS_AC_CLR, w))
        rd_word = act_q[w*32 +: 32];
    end
    for (int p = 0; p < int'(PWORDS); p++)
      if (reg_addr == word_addr(OFS_PRIO, p))
        for (int b = 0; b < 4; b++) rd_word[8*b +: 8] = prio_byte(prio_q[4*p + b]);
    for (int c = 0; c < int'(CWORDS); c++)
      if (reg_addr == word_addr(OFS_CFG, c))
        for (int f = 0; f < 16; f++) rd_word[2*f+1] = edge_q[16*c + f];
    for (int s = 0; s < int'(NUM_IRQ); s++)
      if (reg_addr == word_addr(OFS_STAT, s)) rd_word = status_word(act_q[s], pend_w[s]);
  end

  // ---------------- selection ----------------
  logic [NUM_IRQ-1:0]           grp_ok, elig;
  logic [NUM_IRQ*PRIO_BITS-1:0] prio_flat;
  logic [PRIO_BITS-1:0]         pick_prio;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_flat
    assign prio_flat[i*PRIO_BITS +: PRIO_BITS] = prio_q[i];
  end

  assign grp_ok = (grp_q & {NUM_IRQ{g1_en_q}}) | (~grp_q & {NUM_IRQ{g0_en_q}});
  assign elig   = pend_w & en_q & ~act_q & grp_ok;

  irq_best_pick #(.N(NUM_IRQ), .PB(PRIO_BITS)) u_pick (
    .elig(elig), .prio_flat(prio_flat),
    .found(best_valid), .id(best_id), .prio(pick_prio));

  assign best_prio = best_valid ? prio_byte(pick_prio) : 8'd0;

  // ---------------- assertions ----------------
  assert_busy_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we || clren_we) |=> busy_w);

  assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CNTW'(BUSY_CYCLES));

  assert_pick_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid |-> (en_q[best_id] && pend_w[best_id]));

  assert_pick_not_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
    best_valid |-> !act_q[best_id]);

  assert_none_id_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !best_valid |-> (best_id == ID_NONE && elig == '0));

  assert_rd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

endmodule

// File: tb/irq_dist_regs_bench.sv
module irq_dist_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  localparam logic [12:0] A_CTRL = 13'h000, A_TYPE = 13'h004, A_GROUP = 13'h100;
  localparam logic [12:0] A_EN_SET = 13'h200, A_EN_CLR = 13'h280;
  localparam logic [12:0] A_PD_SET = 13'h300, A_PD_CLR = 13'h380;
  localparam logic [12:0] A_AC_SET = 13'h400, A_AC_CLR = 13'h480;
  localparam logic [12:0] A_PRIO = 13'h800, A_CFG = 13'hC00, A_STAT = 13'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [12:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [N-1:0] irq_in = '0;
  logic        best_valid;
  logic [9:0]  best_id;
  logic [7:0]  best_prio;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    logic [31:0] exp;
    string       req;
    string       what;
  } exp_item_t;

  exp_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dist_regs u_irq_dist_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_in(irq_in), .best_valid(best_valid), .best_id(best_id), .best_prio(best_prio));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // all driver tasks start and end on a falling edge
  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, input logic [31:0] exp,
                    input string req, input string what);
    exp_item_t it;
    it.exp = exp; it.req = req; it.what = what;
    sb_q.push_back(it);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic chk_pick(input string req, input logic v, input int id, input int pr);
    check(req, "best_valid", 32'(best_valid), 32'(v));
    check(req, "best_id", 32'(best_id), 32'(id));
    check(req, "best_prio", 32'(best_prio), 32'(pr));
  endtask

  // monitor: a read sampled at an edge is compared at the following falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (reg_rd) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R1 unexpected read: actual 0x%08h expected none", reg_rdata);
        end else begin
          exp_item_t it;
          it = sb_q.pop_front();
          check(it.req, it.what, reg_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R9 / R12: reset state
    chk_pick("R12", 1'b0, 1023, 0);
    rd(A_CTRL, 32'h0, "R1", "ctrl after reset");
    rd(A_TYPE, 32'h1, "R9", "type word");
    rd(A_EN_SET, 32'h0, "R1", "enable after reset");

    // R2: enable set/clear views
    wr(A_EN_SET, 32'h0000_00F0);
    wr(A_EN_SET, 32'h0);
    rd(A_EN_SET, 32'h0000_00F0, "R2", "enable set view");
    rd(A_EN_CLR, 32'h0000_00F0, "R2", "enable clear view");
    wr(A_EN_SET + 13'd4, 32'h1);
    rd(A_EN_SET + 13'd4, 32'h1, "R2", "enable word 1");
    wr(A_EN_CLR, 32'h0000_0030);
    // R8: clear-enable write raises busy for four reads
    rd(A_CTRL, 32'h8000_0000, "R8", "busy 1 after clr-en");
    rd(A_CTRL, 32'h8000_0000, "R8", "busy 2 after clr-en");
    rd(A_CTRL, 32'h8000_0000, "R8", "busy 3 after clr-en");
    rd(A_CTRL, 32'h8000_0000, "R8", "busy 4 after clr-en");
    rd(A_CTRL, 32'h0, "R8", "busy gone after clr-en");
    rd(A_EN_SET, 32'h0000_00C0, "R2", "enable after clear");

    // R7 / R8: control write, bit 31 not writable
    wr(A_CTRL, 32'h8000_0013);
    rd(A_CTRL, 32'h8000_0013, "R8", "busy 1 after ctrl");
    rd(A_CTRL, 32'h8000_0013, "R8", "busy 2 after ctrl");
    rd(A_CTRL, 32'h8000_0013, "R8", "busy 3 after ctrl");
    rd(A_CTRL, 32'h8000_0013, "R8", "busy 4 after ctrl");
    rd(A_CTRL, 32'h0000_0013, "R7", "ctrl bits after busy");

    // R6: priorities
    wr(A_PRIO + 13'd4, 32'hFFFF_FFFF);
    rd(A_PRIO + 13'd4, 32'hF8F8_F8F8, "R6", "unimplemented low bits");
    wr(A_PRIO + 13'd4, 32'h0810_1020);
    rd(A_PRIO + 13'd4, 32'h0810_1020, "R6", "priority bytes");

    // R3 / R11: pending and selection
    wr(A_PD_SET, 32'h0000_0070);
    chk_pick("R11", 1'b1, 6, 8'h10);
    wr(A_PD_SET, 32'h0000_0080);
    chk_pick("R11", 1'b1, 7, 8'h08);
    wr(A_AC_SET, 32'h0000_0080);
    chk_pick("R11", 1'b1, 6, 8'h10);
    wr(A_EN_SET, 32'h0000_0020);
    chk_pick("R11", 1'b1, 5, 8'h10);
    wr(A_GROUP, 32'h0000_0020);
    rd(A_GROUP, 32'h0000_0020, "R7", "group word");
    wr(A_CTRL, 32'h0000_0001);
    chk_pick("R11", 1'b1, 6, 8'h10);
    wr(A_CTRL, 32'h0000_0003);
    chk_pick("R11", 1'b1, 5, 8'h10);

    // R10: status words
    rd(A_STAT + 13'd28, 32'h3, "R10", "status id7");
    rd(A_STAT + 13'd16, 32'h1, "R10", "status id4");
    rd(A_STAT, 32'h0, "R10", "status id0");
    rd(A_PD_CLR, 32'h0000_00F0, "R3", "pending clear view");
    rd(A_AC_SET, 32'h0000_0080, "R2", "active set view");
    wr(A_AC_CLR, 32'h0000_0080);
    rd(A_AC_CLR, 32'h0, "R2", "active after clear");
    chk_pick("R11", 1'b1, 7, 8'h08);
    wr(A_PD_CLR, 32'h0000_0070);
    rd(A_PD_SET, 32'h0000_0080, "R3", "pending after clear");
    wr(A_PD_CLR, 32'h0000_00FF);
    chk_pick("R12", 1'b0, 1023, 0);

    // R5: level mode on id 40 (word 1 bit 8)
    irq_in[40] = 1'b1;
    rd(A_PD_SET + 13'd4, 32'h0000_0100, "R5", "level pending");
    wr(A_PD_CLR + 13'd4, 32'h0000_0100);
    rd(A_PD_SET + 13'd4, 32'h0000_0100, "R5", "clear ignored while high");
    irq_in[40] = 1'b0;
    rd(A_PD_SET + 13'd4, 32'h0, "R5", "level dropped");
    wr(A_PD_SET + 13'd4, 32'h0000_0100);
    rd(A_PD_SET + 13'd4, 32'h0000_0100, "R5", "level sw pending");
    wr(A_PD_CLR + 13'd4, 32'h0000_0100);
    rd(A_PD_SET + 13'd4, 32'h0, "R5", "level sw cleared");

    // R4: edge mode on id 41 (cfg word 2 bits 19:18, pending word 1 bit 9)
    wr(A_CFG + 13'd8, 32'h000C_0000);
    rd(A_CFG + 13'd8, 32'h0008_0000, "R4", "cfg field readback");
    wr(A_EN_SET + 13'd4, 32'h0000_0200);
    wr(A_PRIO + 13'd40, 32'h0000_1800);
    irq_in[41] = 1'b1;
    @(negedge clk);
    chk_pick("R4", 1'b1, 41, 8'h18);
    irq_in[41] = 1'b0;
    rd(A_PD_SET + 13'd4, 32'h0000_0200, "R4", "edge latched after fall");
    wr(A_PD_CLR + 13'd4, 32'h0000_0200);
    chk_pick("R12", 1'b0, 1023, 0);
    irq_in[41] = 1'b1;
    @(negedge clk);
    wr(A_PD_CLR + 13'd4, 32'h0000_0200);
    rd(A_PD_SET + 13'd4, 32'h0, "R4", "steady high no relatch");
    irq_in[41] = 1'b0;

    @(negedge clk);
    @(negedge clk);
    if (sb_q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL R1 reads outstanding: actual %0d expected 0", sb_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule